// File: doc/BRIEF.md
# Paired-Access Integer Register File

This block is the architectural integer register file of an in-order 32-bit core. It holds thirty-two 32-bit registers. Every access port can work on one register or on an aligned register pair. A pair is an even register and the odd register just above it, and together they are read or written as one 64-bit value. The even register carries the low word and the odd register carries the high word.

There are three independent read ports. Each one has its own pair-mode flag, so any mix of single and pair reads can run in the same cycle. Storage is split into an even bank and an odd bank. Each read port first selects a pair entry using the upper specifier bits. A pair read returns both words of that entry. A single read chooses one of the two words with bit 0 and zero-extends it. The single write port updates one register, or both registers of a pair on the same rising edge. It does this by asserting the even and odd write enables together.

Top module: `pairfile`

## Requirements
- R1: An active-high synchronous reset clears every register; on the cycle after reset all read ports return zero in both modes.
- R2: A single-mode read returns the addressed register in bits 31:0 of its port and zero in bits 63:32.
- R3: A single-mode write stores bits 31:0 of the write data into the addressed register only. Bits 63:32 of the write data and all other registers are left untouched.
- R4: A pair-mode read ignores bit 0 of its specifier. It returns the even register of the pair in bits 31:0 and the odd register in bits 63:32.
- R5: A pair-mode write ignores bit 0 of its specifier. It stores bits 31:0 into the even register and bits 63:32 into the odd register on the same clock edge.
- R6: Register 0 always reads as zero and is never written. A pair write to registers 0 and 1 still updates register 1.
- R7: The three read ports are independent, and any combination of them may be in pair mode in the same cycle.
- R8: Writes take effect on the rising clock edge. A read of the register being written in the same cycle returns the old contents.
- R9: With the write enable low, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx | input | NRD*AW (15) | Read specifiers, port k in bits k*AW +: AW |
| rd_pair | input | NRD (3) | Per-port mode: 1 = pair, 0 = single |
| rd_data | output | NRD*2*XW (192) | Read data, port k in bits k*2*XW +: 2*XW |
| wr_en | input | 1 | Write enable |
| wr_pair | input | 1 | Write mode: 1 = pair, 0 = single |
| wr_idx | input | AW (5) | Write specifier |
| wr_data | input | 2*XW (64) | Write data; only bits 31:0 are used in single mode |

## Verification
The bench sweeps every specifier in both modes on all three ports at once. The ports are rotated to different registers with opposite modes, which separates a port-select error from a mode-select error. The contents are built three ways: all zero after reset, a distinct single-written word per register with junk in the upper write half, and distinct 64-bit values written as pairs, including through odd specifiers. These separate a swapped half, a leaked upper half and a bit-0 that is not ignored. Separate stimuli cover register 0 as a single target and as a pair base, a write with the enable low, and a read of the register being written in the same cycle.

// File: rtl/pairfile_pkg.sv
package pairfile_pkg;
   typedef enum logic {
      ACC_SINGLE = 1'b0,
      ACC_PAIR   = 1'b1
   } acc_mode_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/pairfile_wdec.sv
module pairfile_wdec
   import pairfile_pkg::*;
#(
   parameter int XW    = 32,
   parameter int NPAIR = 16,
   localparam int PW   = $clog2(NPAIR),
   localparam int AW   = PW + 1
) (
   input  logic              wr_en,
   input  logic              wr_pair,
   input  logic [AW-1:0]     wr_idx,
   input  logic [2*XW-1:0]   wr_data,
   output logic [NPAIR-1:0]  ev_we,
   output logic [NPAIR-1:0]  od_we,
   output logic [XW-1:0]     ev_wd,
   output logic [XW-1:0]     od_wd
);
   logic [PW-1:0] base;
   logic          pair_mode;
   logic          want_ev;
   logic          want_od;

   assign base      = wr_idx[AW-1:1];
   assign pair_mode = (acc_mode_e'(wr_pair) == ACC_PAIR);
   assign want_ev   = pair_mode || !wr_idx[0];
   assign want_od   = pair_mode ||  wr_idx[0];

   // Even word always gets the low half; odd word gets the high half only for pairs.
   assign ev_wd = wr_data[XW-1:0];
   assign od_wd = pair_mode ? wr_data[2*XW-1:XW] : wr_data[XW-1:0];

   for (genvar p = 0; p < NPAIR; p++) begin : g_dec
      logic hit;
      assign hit = wr_en && (base == PW'(p));
      if (p == 0) begin : g_zero
         // Register 0 is hard-wired: its enable never fires.
         assign ev_we[p] = 1'b0;
      end else begin : g_norm
         assign ev_we[p] = hit && want_ev;
      end
      assign od_we[p] = hit && want_od;
   end
endmodule

// File: rtl/pairfile_bank.sv
module pairfile_bank #(
   parameter int XW    = 32,
   parameter int NPAIR = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NPAIR-1:0]    ev_we,
   input  logic [NPAIR-1:0]    od_we,
   input  logic [XW-1:0]       ev_wd,
   input  logic [XW-1:0]       od_wd,
   output logic [NPAIR*XW-1:0] ev_q,
   output logic [NPAIR*XW-1:0] od_q
);
   for (genvar p = 0; p < NPAIR; p++) begin : g_ent
      logic [XW-1:0] ev_r;
      logic [XW-1:0] od_r;

      always_ff @(posedge clk) begin
         if (rst)           ev_r <= '0;
         else if (ev_we[p]) ev_r <= ev_wd;
      end

      always_ff @(posedge clk) begin
         if (rst)           od_r <= '0;
         else if (od_we[p]) od_r <= od_wd;
      end

      assign ev_q[p*XW +: XW] = ev_r;
      assign od_q[p*XW +: XW] = od_r;
   end
endmodule

// File: rtl/pairfile_rport.sv
module pairfile_rport
   import pairfile_pkg::*;
#(
   parameter int XW    = 32,
   parameter int NPAIR = 16,
   localparam int PW   = $clog2(NPAIR),
   localparam int AW   = PW + 1
) (
   input  logic [NPAIR*XW-1:0] ev_q,
   input  logic [NPAIR*XW-1:0] od_q,
   input  logic [AW-1:0]       idx,
   input  logic                pair,
   output logic [2*XW-1:0]     data
);
   logic [XW-1:0] ev_a [NPAIR];
   logic [XW-1:0] od_a [NPAIR];
   logic [XW-1:0] ev_s;
   logic [XW-1:0] od_s;

   for (genvar p = 0; p < NPAIR; p++) begin : g_unpack
      assign ev_a[p] = ev_q[p*XW +: XW];
      assign od_a[p] = od_q[p*XW +: XW];
   end

   // Upper levels of the tree pick the pair entry; bit 0 is the last level.
   assign ev_s = ev_a[idx[AW-1:1]];
   assign od_s = od_a[idx[AW-1:1]];

   always_comb begin
      if (acc_mode_e'(pair) == ACC_PAIR) data = {od_s, ev_s};
      else                               data = {{XW{1'b0}}, (idx[0] ? od_s : ev_s)};
   end
endmodule

// File: rtl/pairfile.sv
module pairfile
   import pairfile_pkg::*;
#(
   parameter int XW    = 32,
   parameter int NREG  = 32,
   parameter int NRD   = 3,
   localparam int NPAIR = NREG / 2,
   localparam int AW    = $clog2(NREG)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NRD*AW-1:0]     rd_idx,
   input  logic [NRD-1:0]        rd_pair,
   output logic [NRD*2*XW-1:0]   rd_data,
   input  logic                  wr_en,
   input  logic                  wr_pair,
   input  logic [AW-1:0]         wr_idx,
   input  logic [2*XW-1:0]       wr_data
);
   if (!is_pow2(NREG) || NREG < 4) begin : g_bad_nreg
      $error("pairfile: NREG must be a power of two and at least 4");
   end
   if (XW < 1) begin : g_bad_xw
      $error("pairfile: XW must be positive");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("pairfile: NRD must be at least 1");
   end

   logic [NPAIR-1:0]    ev_we;
   logic [NPAIR-1:0]    od_we;
   logic [XW-1:0]       ev_wd;
   logic [XW-1:0]       od_wd;
   logic [NPAIR*XW-1:0] ev_q;
   logic [NPAIR*XW-1:0] od_q;

   pairfile_wdec #(.XW(XW), .NPAIR(NPAIR)) u_wdec (
      .wr_en   (wr_en),
      .wr_pair (wr_pair),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .ev_we   (ev_we),
      .od_we   (od_we),
      .ev_wd   (ev_wd),
      .od_wd   (od_wd)
   );

   pairfile_bank #(.XW(XW), .NPAIR(NPAIR)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .ev_we (ev_we),
      .od_we (od_we),
      .ev_wd (ev_wd),
      .od_wd (od_wd),
      .ev_q  (ev_q),
      .od_q  (od_q)
   );

   for (genvar k = 0; k < NRD; k++) begin : g_rd
      pairfile_rport #(.XW(XW), .NPAIR(NPAIR)) u_rport (
         .ev_q (ev_q),
         .od_q (od_q),
         .idx  (rd_idx[k*AW +: AW]),
         .pair (rd_pair[k]),
         .data (rd_data[k*2*XW +: 2*XW])
      );
   end
endmodule

// File: rtl/pairfile_chk.sv
module pairfile_chk #(
   parameter int XW    = 32,
   parameter int NREG  = 32,
   parameter int NRD   = 3,
   localparam int AW   = $clog2(NREG)
) (
   input logic                clk,
   input logic                rst,
   input logic [NRD*AW-1:0]   rd_idx,
   input logic [NRD-1:0]      rd_pair,
   input logic [NRD*2*XW-1:0] rd_data,
   input logic                wr_en,
   input logic                wr_pair,
   input logic [AW-1:0]       wr_idx,
   input logic [2*XW-1:0]     wr_data
);
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (rd_data == '0));

   assert_hold_no_we_R9: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !$past(wr_en) && $stable(rd_idx) && $stable(rd_pair))
      |-> $stable(rd_data));

   for (genvar k = 0; k < NRD; k++) begin : g_port
      logic [AW-1:0]   ix;
      logic            pr;
      logic [XW-1:0]   lo;
      logic [XW-1:0]   hi;
      assign ix = rd_idx[k*AW +: AW];
      assign pr = rd_pair[k];
      assign lo = rd_data[k*2*XW +: XW];
      assign hi = rd_data[k*2*XW + XW +: XW];

      assert_single_zext_R2: assert property (@(posedge clk) disable iff (rst)
         !pr |-> (hi == '0));

      assert_x0_zero_R6: assert property (@(posedge clk) disable iff (rst)
         ((ix[AW-1:1] == '0) && (pr || !ix[0])) |-> (lo == '0));

      assert_single_wr_rd_R3: assert property (@(posedge clk) disable iff (rst)
         ($past(!rst) && $past(wr_en) && !$past(wr_pair) && ($past(wr_idx) != '0)
          && !pr && (ix == $past(wr_idx)))
         |-> (lo == $past(wr_data[XW-1:0])));

      assert_pair_wr_rd_R5: assert property (@(posedge clk) disable iff (rst)
         ($past(!rst) && $past(wr_en) && $past(wr_pair) && pr
          && (ix[AW-1:1] == $past(wr_idx[AW-1:1])))
         |-> (hi == $past(wr_data[2*XW-1:XW])));
   end

   if (NRD >= 2) begin : g_cross
      assert_pair_bit0_ignored_R4: assert property (@(posedge clk) disable iff (rst)
         (rd_pair[0] && rd_pair[1] && (rd_idx[AW-1:1] == rd_idx[2*AW-1:AW+1]))
         |-> (rd_data[2*XW-1:0] == rd_data[4*XW-1:2*XW]));
   end
endmodule

bind pairfile pairfile_chk #(.XW(XW), .NREG(NREG), .NRD(NRD)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .rd_idx  (rd_idx),
   .rd_pair (rd_pair),
   .rd_data (rd_data),
   .wr_en   (wr_en),
   .wr_pair (wr_pair),
   .wr_idx  (wr_idx),
   .wr_data (wr_data)
);

// File: tb/pairfile_test.sv
`timescale 1ns/1ps
module pairfile_test;
   localparam int XW = 32, NREG = 32, NRD = 3, AW = 5;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [NRD*AW-1:0]   rd_idx = '0;
   logic [NRD-1:0]      rd_pair = '0;
   logic [NRD*2*XW-1:0] rd_data;
   logic                wr_en = 1'b0;
   logic                wr_pair = 1'b0;
   logic [AW-1:0]       wr_idx = '0;
   logic [2*XW-1:0]     wr_data = '0;

   int n_chk = 0;
   int n_bad = 0;
   logic [XW-1:0] mdl [NREG];

   always #2 clk = ~clk;

   pairfile #(.XW(XW), .NREG(NREG), .NRD(NRD)) uut (
      .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_pair(rd_pair), .rd_data(rd_data),
      .wr_en(wr_en), .wr_pair(wr_pair), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   function automatic logic [2*XW-1:0] expect_rd(input int idx, input bit pr);
      int b;
      if (pr) begin
         b = idx & ~1;
         return {mdl[b+1], (b == 0) ? 32'h0 : mdl[b]};
      end
      return {32'h0, (idx == 0) ? 32'h0 : mdl[idx]};
   endfunction

   task automatic check(input string req, input logic [2*XW-1:0] act, input logic [2*XW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Every specifier in both modes, three ports rotated with mixed modes (R7).
   task automatic sweep(input string tag);
      for (int i = 0; i < NREG; i++) begin
         for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            for (int k = 0; k < NRD; k++) begin
               rd_idx[k*AW +: AW] = AW'((i + 7*k) % NREG);
               rd_pair[k] = (m != 0) ^ (k == 1);
            end
            #1;
            for (int k = 0; k < NRD; k++) begin
               int ix;
               bit pr;
               ix = (i + 7*k) % NREG;
               pr = (m != 0) ^ (k == 1);
               check($sformatf("%s %s R7 port%0d idx%0d", tag, pr ? "R4" : "R2", k, ix),
                     rd_data[k*2*XW +: 2*XW], expect_rd(ix, pr));
            end
         end
      end
   endtask

   task automatic do_write(input bit en, input bit pr, input int idx, input logic [2*XW-1:0] d);
      int b;
      @(negedge clk);
      wr_en = en; wr_pair = pr; wr_idx = AW'(idx); wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      if (en) begin
         if (pr) begin
            b = idx & ~1;
            if (b != 0) mdl[b] = d[XW-1:0];
            mdl[b+1] = d[2*XW-1:XW];
         end else if (idx != 0) begin
            mdl[idx] = d[XW-1:0];
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NREG; i++) mdl[i] = '0;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < NREG; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      sweep("R1 reset");

      // Single writes with junk in the upper half (R3, R6 via index 0).
      for (int i = 0; i < NREG; i++)
         do_write(1'b1, 1'b0, i, {32'hDEAD0000 | 32'(i), 32'h13579BDF ^ (32'(i) * 32'h01010101)});
      sweep("R3 single-wr");

      // Pair writes through even and odd specifiers (R5), incl. base 0 (R6).
      for (int i = 0; i < NREG; i += 2)
         do_write(1'b1, 1'b1, i + ((i >> 1) & 1),
                  {32'hC0DE0000 | 32'(i), 32'h0000BEEF + 32'(i) * 32'h11110000});
      sweep("R5 pair-wr");

      // Pair write to registers 0/1 and single write to 0 (R6).
      do_write(1'b1, 1'b1, 1, 64'hAAAA5555_12345678);
      do_write(1'b1, 1'b0, 0, 64'h0000_0000_FFFFFFFF);
      @(negedge clk);
      rd_idx[0 +: AW] = 5'd0; rd_pair[0] = 1'b1;
      #1;
      check("R6 pair x0/x1", rd_data[0 +: 2*XW], {32'hAAAA5555, 32'h0});

      // Write enable low changes nothing (R9).
      do_write(1'b0, 1'b0, 10, 64'hFFFFFFFF_FFFFFFFF);
      do_write(1'b0, 1'b1, 12, 64'hFFFFFFFF_FFFFFFFF);
      sweep("R9 no-we");

      // Same-cycle read returns old value, new after the edge (R8).
      @(negedge clk);
      rd_idx[0 +: AW] = 5'd9; rd_pair[0] = 1'b0;
      rd_idx[AW +: AW] = 5'd12; rd_pair[1] = 1'b1;
      wr_en = 1'b1; wr_pair = 1'b0; wr_idx = 5'd9; wr_data = 64'h0_0BADF00D;
      #1;
      check("R8 old value", rd_data[0 +: 2*XW], {32'h0, mdl[9]});
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      mdl[9] = 32'h0BADF00D;
      check("R8 new value", rd_data[0 +: 2*XW], {32'h0, 32'h0BADF00D});
      @(negedge clk);
      wr_en = 1'b1; wr_pair = 1'b1; wr_idx = 5'd13; wr_data = 64'h11112222_33334444;
      #1;
      check("R8 pair old", rd_data[2*XW +: 2*XW], {mdl[13], mdl[12]});
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      mdl[12] = 32'h33334444; mdl[13] = 32'h11112222;
      check("R8 pair new", rd_data[2*XW +: 2*XW], 64'h11112222_33334444);

      // Reset in mid-run clears everything (R1).
      do_reset();
      sweep("R1 mid-reset");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule